// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries one 8-bit voice sample per frame in each direction between a parallel byte interface and a time-slotted serial PCM bus. The serial side has a bit clock, a frame sync, a receive data input, and a transmit data output with a separate output enable. The enable is high only during the transmit slot, so an external tri-state buffer can share the line with other devices. The parallel side takes one transmit byte per frame. It returns each received byte together with a one-cycle strobe.

The block runs on a fast system clock `clk`. The bit clock and frame sync are sampled by `clk`, so they must be synchronous to it. Each bit-clock level must last at least one `clk` cycle. A bit-clock edge takes effect at the first `clk` edge that sees the new level, and the outputs change at that same edge. Four configuration inputs are expected to change only while no frame is in progress:

- the frame format;
- the rate code, which sets the number of bit periods per frame;
- the transmit slot;
- the receive slot.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst_n` is low and afterwards until the first frame starts, `ser_oe`, `ser_out` and `rx_strobe` are 0, and `rx_byte` is 0.
- R2: `ser_oe` is 1 only during the 8 bit periods of the transmit slot, where slot n covers frame bit indices 8n to 8n+7. `ser_out` is 0 whenever `ser_oe` is 0.
- R3: For `fmt` codes 0 and 3 (non-delayed normal) and code 1 (delayed), transmit bits change on the rising edge of `bit_clk`, and `ser_in` is sampled on its falling edge.
- R4: For `fmt` code 2 (non-delayed reverse), transmit bits change on the falling edge of `bit_clk`, and `ser_in` is sampled on its rising edge.
- R5: A frame starts at a launch edge where `frame_sync` is 1 and was 0 at the previous launch edge. In the non-delayed formats, bit index 0 is launched at that same edge. In the delayed format, bit index 0 is launched one bit period later.
- R6: The bit at frame index 8n+j of slot n carries byte bit 7-j, so the most significant bit goes first in both directions.
- R7: `rate_sel` codes 0, 1, 2 and 3 give 64, 192, 256 and 320 bit periods per frame. A slot number of at least (bits per frame)/8 disables transfer in that direction.
- R8: `tx_byte` is captured at the launch edge of bit index 0. Changes to `tx_byte` after that edge do not affect the frame in progress.
- R9: After the sample edge of the last bit of the receive slot, `rx_strobe` is 1 for exactly one `clk` cycle, and `rx_byte` then shows the byte assembled from that slot. `rx_byte` holds this value until the next strobe.
- R10: If no new frame start arrives, the frame ends after its last bit index. After that, `ser_oe` and `rx_strobe` stay 0 until the next frame start.
- R11: In the delayed format, a frame sync that falls on the bit period carrying the previous frame's last bit does not cut that bit. The bit is still sent and received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, synchronous to clk |
| frame_sync | input | 1 | Frame sync, high for one bit period |
| fmt | input | 2 | Frame format: 0/3 normal, 1 delayed, 2 reverse |
| rate_sel | input | 2 | Bits per frame: 64, 192, 256, 320 |
| tx_slot | input | 6 | Transmit slot number |
| rx_slot | input | 6 | Receive slot number |
| tx_byte | input | 8 | Byte to send in the next frame |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Transmit output enable |
| rx_byte | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse marking a new rx_byte |

## Verification
In the delayed format, the frame-start detection for the next frame and the last-bit transfer of the current frame fall on the same launch edge. This happens when frames follow each other with no gap and a slot sits at the end of the frame. The bench provokes this by running back-to-back delayed frames with both slots placed in the final slot. It also changes `tx_byte` on exactly that edge. The result is judged in two ways. The final transmit byte reassembled from `ser_out` must be the byte latched earlier, not the new one. The byte delivered with `rx_strobe` must match what was driven, including the bit that crosses the frame sync.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  typedef enum logic [1:0] {
    FMT_NORMAL  = 2'd0,
    FMT_DELAYED = 2'd1,
    FMT_REVERSE = 2'd2,
    FMT_NORMAL2 = 2'd3
  } fmt_e;

  // Bit periods per frame for each rate code.
  function automatic int frame_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 64;
      2'd1:    return 192;
      2'd2:    return 256;
      default: return 320;
    endcase
  endfunction

  // A slot is usable when it starts inside the frame.
  function automatic logic slot_fits(input int slot, input logic [1:0] sel, input int w);
    return slot < (frame_bits(sel) / w);
  endfunction

  function automatic logic is_reverse(input logic [1:0] f);
    return f == FMT_REVERSE;
  endfunction

  function automatic logic is_delayed(input logic [1:0] f);
    return f == FMT_DELAYED;
  endfunction

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det
  import pcm_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_clk,
  input  logic [1:0] fmt,
  output logic       launch,
  output logic       sample
);
  logic clk_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= bit_clk;
  end

  always_comb begin
    rise   = bit_clk & ~clk_q;
    fall   = ~bit_clk & clk_q;
    launch = is_reverse(fmt) ? fall : rise;
    sample = is_reverse(fmt) ? rise : fall;
  end
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr
  import pcm_slot_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             fs,
  input  logic             delayed,
  input  logic [1:0]       sel,
  output logic             nxt_run,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             cur_run,
  output logic [IDX_W-1:0] cur_idx,
  output logic             start0
);
  logic pend;
  logic nxt_pend;
  logic fs_prev;
  logic fs_edge;
  logic last;

  always_comb begin
    fs_edge  = launch && fs && !fs_prev;
    last     = (int'(cur_idx) == frame_bits(sel) - 1);
    nxt_run  = cur_run;
    nxt_idx  = cur_idx;
    nxt_pend = pend;
    start0   = 1'b0;
    if (launch) begin
      if (fs_edge && !delayed) begin
        nxt_run  = 1'b1;
        nxt_idx  = '0;
        nxt_pend = 1'b0;
        start0   = 1'b1;
      end else begin
        if (pend) begin
          nxt_run = 1'b1;
          nxt_idx = '0;
          start0  = 1'b1;
        end else if (cur_run) begin
          if (last) nxt_run = 1'b0;
          else      nxt_idx = cur_idx + IDX_W'(1);
        end
        // a delayed-format sync arms the next edge; the current bit still runs
        nxt_pend = fs_edge;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_run <= 1'b0;
      cur_idx <= '0;
      pend    <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      cur_run <= nxt_run;
      cur_idx <= nxt_idx;
      pend    <= nxt_pend;
      if (launch) fs_prev <= fs;
    end
  end
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_slot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int OFF_W  = $clog2(DATA_W),
  localparam int SLOT_W = IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              start0,
  input  logic              nxt_run,
  input  logic [IDX_W-1:0]  nxt_idx,
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              ser_out,
  output logic              ser_oe
);
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] byte_now;
  logic [OFF_W-1:0]  off;
  logic              in_slot;

  always_comb begin
    byte_now = start0 ? tx_byte : hold;
    off      = nxt_idx[OFF_W-1:0];
    in_slot  = nxt_run && slot_fits(int'(slot), sel, DATA_W)
               && (nxt_idx[IDX_W-1:OFF_W] == slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= '0;
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else if (launch) begin
      if (start0) hold <= tx_byte;
      ser_oe  <= in_slot;
      ser_out <= in_slot ? byte_now[~off] : 1'b0;
    end
  end
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_slot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int OFF_W  = $clog2(DATA_W),
  localparam int SLOT_W = IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              cur_run,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        sel,
  input  logic              ser_in,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_strobe
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shifted;
  logic              take;
  logic              final_bit;

  always_comb begin
    take      = sample && cur_run && slot_fits(int'(slot), sel, DATA_W)
                && (cur_idx[IDX_W-1:OFF_W] == slot);
    final_bit = &cur_idx[OFF_W-1:0];
    shifted   = {shreg[DATA_W-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (take) begin
        shreg <= shifted;
        if (final_bit) begin
          rx_byte   <= shifted;
          rx_strobe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int OFF_W  = $clog2(DATA_W),
  localparam int SLOT_W = IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              frame_sync,
  input  logic [1:0]        fmt,
  input  logic [1:0]        rate_sel,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_strobe
);
  // named internal events, also watched by the checker
  logic             launch_w;
  logic             sample_w;
  logic             nrun_w;
  logic [IDX_W-1:0] nidx_w;
  logic             run_w;
  logic [IDX_W-1:0] idx_w;
  logic             start_w;

  pcm_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .fmt(fmt),
    .launch(launch_w), .sample(sample_w)
  );

  pcm_frame_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .fs(frame_sync),
    .delayed(is_delayed(fmt)), .sel(rate_sel),
    .nxt_run(nrun_w), .nxt_idx(nidx_w),
    .cur_run(run_w), .cur_idx(idx_w), .start0(start_w)
  );

  pcm_tx #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .start0(start_w),
    .nxt_run(nrun_w), .nxt_idx(nidx_w), .slot(tx_slot), .sel(rate_sel),
    .tx_byte(tx_byte), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  pcm_rx #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample_w), .cur_run(run_w),
    .cur_idx(idx_w), .slot(rx_slot), .sel(rate_sel), .ser_in(ser_in),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk
  import pcm_slot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch,
  input logic              sample,
  input logic              run,
  input logic              ser_oe,
  input logic              ser_out,
  input logic              rx_strobe,
  input logic [DATA_W-1:0] rx_byte,
  input logic [SLOT_W-1:0] tx_slot,
  input logic [1:0]        rate_sel
);
  // R3 / R4: the enable only moves at a launch edge of the active format
  p_oe_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_oe) |-> $past(launch));

  p_strobe_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $past(sample));

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |-> $stable(rx_byte));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_out);

  p_oe_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> run);

  p_slot_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> slot_fits(int'(tx_slot), rate_sel, DATA_W));
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch_w), .sample(sample_w), .run(run_w),
  .ser_oe(ser_oe), .ser_out(ser_out), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
  .tx_slot(tx_slot), .rate_sel(rate_sel)
);

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_clk = 1'b0;
  logic       frame_sync = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [1:0] rate_sel = 2'd0;
  logic [5:0] tx_slot = 6'd0;
  logic [5:0] rx_slot = 6'd0;
  logic [7:0] tx_byte = 8'd0;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       ser_oe;
  logic [7:0] rx_byte;
  logic       rx_strobe;

  pcm_slot_port u0 (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
    .fmt(fmt), .rate_sel(rate_sel), .tx_slot(tx_slot), .rx_slot(rx_slot),
    .tx_byte(tx_byte), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_run = 0, m_idx = 0, m_pend = 0, m_fsp = 0, m_hold = 0;
  int m_dx = 0, m_oe = 0, m_sh = 0, m_rxd = 0, m_rxv = 0, m_clk = 0;
  int c_md = 0, c_sel = 0, c_ts = 0, c_rs = 0;
  int txq[$];
  int rxq[$];
  int cap_n = 0, cap_v = 0, oe_seen = 0, stb_seen = 0;
  string tag = "R1";

  function automatic int fbits(input int s);
    if (s == 0) return 64;
    if (s == 1) return 192;
    if (s == 2) return 256;
    return 320;
  endfunction

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic step(input bit mc, input bit fsv, input bit drv);
    int rise, fall, ln, sm, fe, st0, e;
    @(negedge clk);
    chk(int'(ser_oe) == m_oe, "R2", "ser_oe vs model", int'(ser_oe), m_oe);
    chk(int'(ser_out) == m_dx, "R6", "ser_out vs model", int'(ser_out), m_dx);
    chk(int'(rx_strobe) == m_rxv, "R9", "rx_strobe vs model", int'(rx_strobe), m_rxv);
    chk(int'(rx_byte) == m_rxd, "R9", "rx_byte vs model", int'(rx_byte), m_rxd);
    if (rx_strobe) begin
      stb_seen++;
      if (rxq.size() == 0) chk(1'b0, tag, "unexpected rx byte", int'(rx_byte), -1);
      else begin
        e = rxq.pop_front();
        chk(int'(rx_byte) == e, tag, "received byte", int'(rx_byte), e);
      end
    end
    bit_clk = mc; frame_sync = fsv; ser_in = drv;
    // predict the state after the coming rising clk edge
    rise = (mc && m_clk == 0) ? 1 : 0;
    fall = (!mc && m_clk == 1) ? 1 : 0;
    m_clk = mc ? 1 : 0;
    ln = (c_md == 2) ? fall : rise;
    sm = (c_md == 2) ? rise : fall;
    m_rxv = 0;
    if (sm && m_run && c_rs < fbits(c_sel) / 8 && m_idx / 8 == c_rs) begin
      m_sh = ((m_sh << 1) | int'(drv)) & 255;
      if (m_idx % 8 == 7) begin m_rxd = m_sh; m_rxv = 1; end
    end
    if (ln) begin
      fe = (fsv && m_fsp == 0) ? 1 : 0;
      m_fsp = fsv ? 1 : 0;
      st0 = 0;
      if (fe && c_md != 1) begin
        m_run = 1; m_idx = 0; m_pend = 0; st0 = 1;
      end else begin
        if (m_pend) begin m_run = 1; m_idx = 0; st0 = 1; end
        else if (m_run) begin
          if (m_idx == fbits(c_sel) - 1) m_run = 0;
          else m_idx++;
        end
        m_pend = fe;
      end
      if (st0) m_hold = int'(tx_byte);
      m_oe = (m_run && c_ts < fbits(c_sel) / 8 && m_idx / 8 == c_ts) ? 1 : 0;
      m_dx = m_oe ? (m_hold >> (7 - m_idx % 8)) & 1 : 0;
    end
  endtask

  // one bit period: launch half, then sample half
  task automatic period(input bit fsv, input bit drv);
    bit lv;
    int e;
    lv = (c_md == 2) ? 1'b0 : 1'b1;
    repeat (HALF) step(lv, fsv, drv);
    if (ser_oe) begin
      oe_seen++;
      cap_v = ((cap_v << 1) | int'(ser_out)) & 255;
      cap_n++;
      if (cap_n == 8) begin
        cap_n = 0;
        if (txq.size() == 0) chk(1'b0, tag, "unexpected tx byte", cap_v, -1);
        else begin
          e = txq.pop_front();
          chk(cap_v == e, tag, "sent byte", cap_v, e);
        end
      end
    end
    repeat (HALF) step(!lv, fsv, drv);
  endtask

  task automatic run_cfg(input int md, input int sel, input int ts, input int rs,
                         input int nfr, input string t);
    int n, s, k, prevrx, txb, rxb, oe0, stb0;
    bit d;
    c_md = md; c_sel = sel; c_ts = ts; c_rs = rs; tag = t;
    fmt = 2'(md); rate_sel = 2'(sel); tx_slot = 6'(ts); rx_slot = 6'(rs);
    n = fbits(sel); s = n / 8; prevrx = 0;
    repeat (HALF) step((md == 2) ? 1'b1 : 1'b0, 1'b0, 1'b0);
    for (int f = 0; f < nfr; f++) begin
      txb = (f * 73 + md * 17 + 90) & 255;
      rxb = (f * 151 + ts * 7 + 195) & 255;
      if (ts < s) txq.push_back(txb);
      if (rs < s) rxq.push_back(rxb);
      for (int p = 0; p < n; p++) begin
        if (p == 0) tx_byte = 8'(txb);  // changes on the sync period (R8)
        k = (md == 1) ? p - 1 : p;
        if (k < 0) d = (f > 0 && rs == s - 1) ? 1'(prevrx & 1) : 1'($urandom_range(1, 0));
        else if (k / 8 == rs) d = 1'((rxb >> (7 - k % 8)) & 1);
        else d = 1'($urandom_range(1, 0));
        period(p == 0, d);
      end
      prevrx = rxb;
    end
    if (md == 1) period(1'b0, (rs == s - 1) ? 1'(prevrx & 1) : 1'($urandom_range(1, 0)));
    // R10: no sync any more, nothing may move
    oe0 = oe_seen; stb0 = stb_seen;
    for (int i = 0; i < n + 2; i++) period(1'b0, 1'($urandom_range(1, 0)));
    chk(oe_seen == oe0, "R10", "enable after frame end", oe_seen - oe0, 0);
    chk(stb_seen == stb0, "R10", "strobe after frame end", stb_seen - stb0, 0);
    chk(txq.size() == 0, tag, "tx bytes not sent", txq.size(), 0);
    chk(rxq.size() == 0, tag, "rx bytes not received", rxq.size(), 0);
    chk(cap_n == 0, tag, "partial tx byte", cap_n, 0);
    txq.delete(); rxq.delete(); cap_n = 0;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ser_oe == 1'b0, "R1", "reset ser_oe", int'(ser_oe), 0);
    chk(ser_out == 1'b0, "R1", "reset ser_out", int'(ser_out), 0);
    chk(rx_strobe == 1'b0, "R1", "reset rx_strobe", int'(rx_strobe), 0);
    chk(rx_byte == 8'd0, "R1", "reset rx_byte", int'(rx_byte), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk(ser_oe == 1'b0, "R1", "idle after reset", int'(ser_oe), 0);
    run_cfg(0, 0, 0, 7, 3, "R3 R5 R6");
    run_cfg(1, 0, 7, 7, 3, "R5 R8 R11");
    run_cfg(2, 1, 23, 0, 2, "R4");
    run_cfg(1, 2, 31, 12, 2, "R5 R7");
    run_cfg(0, 3, 39, 40, 2, "R7");
    run_cfg(2, 0, 8, 3, 2, "R4 R7");
    run_cfg(3, 0, 1, 1, 2, "R3");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule